// File: doc/BRIEF.md
# Hop-Edge Front-End Power Sequencer

This block times the power enables of a frequency-hopping, time-division transceiver. Each pulse on `hop` marks the boundary between two frames on air. The direction of the new frame is sampled from `dir_tx` on the same edge, so one edge can end a receive frame and start a transmit frame, or the reverse. From that edge the block drives five enables: receive analog section, receive LNA, transmit analog section, and the receive and transmit data interfaces. Every rise is placed by a programmed delay, counted in clock cycles from the hop edge.

Every output that the new frame does not need turns off on the hop edge itself. The one exception is the receive data interface, which may stay on for a programmed hold time so that late samples still reach the baseband.

Two rules keep the analog sections apart. When a transmit frame is followed by a receive frame, the receive analog power-up is pushed back to a guard-time floor. In PLL-retune mode, each analog power-up waits for the larger of its own delay and the retune time. A second hop edge during a countdown cancels every pending rise, and the new frame's rises are counted from the newer edge.

Top module: `hop_power_seq`

## Requirements
- R1: On the clock edge that samples `hop`=1, every enable of the direction not chosen by `dir_tx` is 0 from that edge on: `tx_ana_en`/`tx_if_en` when `dir_tx`=0 (receive), `rx_ana_en`/`rx_lna_en` when `dir_tx`=1 (transmit).
- R2: `rx_ana_en` and `tx_ana_en` are never 1 in the same cycle.
- R3: In a receive frame, `rx_ana_en` rises D clock edges after the hop edge, where D=0 means on the hop edge itself. D = `rx_ana_on_dly`, raised to `guard_dly` when the previous frame was transmit. After reset the previous frame counts as receive.
- R4: In a transmit frame, `tx_ana_en` rises `tx_ana_on_dly` edges after the hop edge, with no floor applied.
- R5: `rx_lna_en` rises and falls on the same edges as `rx_ana_en`, so its power-down delay is zero.
- R6: If `rx_if_en` is 1 when a hop edge is sampled, it stays 1 for `rx_if_hold_dly` further cycles after that edge, whatever the new direction, and then falls unless the new receive frame has turned it on.
- R7: `rx_if_en` rises `rx_if_on_dly` edges after the hop edge in receive frames, and `tx_if_en` rises `tx_if_on_dly` edges after the hop edge in transmit frames. Neither delay is affected by the guard time or by retune mode.
- R8: With `retune_en`=1, both analog rises use max(their R3/R4 delay, `pll_retune_dly`).
- R9: A hop edge arriving while a rise is still pending cancels it, and the new frame's rises are timed from the new edge.
- R10: While `rst_n` is 0, all five enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hop | input | 1 | One-cycle hop-edge strobe |
| dir_tx | input | 1 | Direction of the frame starting at this hop: 1 transmit, 0 receive |
| retune_en | input | 1 | PLL-retune mode |
| rx_ana_on_dly | input | W | Receive analog power-up delay, cycles |
| tx_ana_on_dly | input | W | Transmit analog power-up delay, cycles |
| guard_dly | input | W | Floor for receive power-up after a transmit frame |
| pll_retune_dly | input | W | PLL retune time, cycles |
| rx_if_on_dly | input | W | Receive interface enable delay |
| tx_if_on_dly | input | W | Transmit interface enable delay |
| rx_if_hold_dly | input | W | Receive interface hold after a hop edge |
| rx_ana_en | output | 1 | Receive analog power enable |
| rx_lna_en | output | 1 | Receive LNA power enable |
| tx_ana_en | output | 1 | Transmit analog power enable |
| rx_if_en | output | 1 | Receive data interface enable |
| tx_if_en | output | 1 | Transmit data interface enable |

## Verification
The sweep runs every direction transition with guard times below, equal to and above the receive delay, and with retune off and on. A design that applied the floor after a receive frame, or ignored it after a transmit frame, puts the receive rise on the wrong cycle. Zero delays and a zero hold cover the edge-aligned cases, where an off-by-one counter shifts a transition by a cycle. A truncated frame shows whether a stale countdown survives a new hop edge: a sequencer that fails this raises an enable for the wrong direction or at the old time.

// File: rtl/hop_power_seq.sv
module hop_power_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hop,
  input  logic         dir_tx,
  input  logic         retune_en,
  input  logic [W-1:0] rx_ana_on_dly,
  input  logic [W-1:0] tx_ana_on_dly,
  input  logic [W-1:0] guard_dly,
  input  logic [W-1:0] pll_retune_dly,
  input  logic [W-1:0] rx_if_on_dly,
  input  logic [W-1:0] tx_if_on_dly,
  input  logic [W-1:0] rx_if_hold_dly,
  output logic         rx_ana_en,
  output logic         rx_lna_en,
  output logic         tx_ana_en,
  output logic         rx_if_en,
  output logic         tx_if_en
);
  localparam int NCH = 4;

  logic         cur_tx;
  logic [W-1:0] rx_base, rx_eff, tx_eff;
  logic [W-1:0] dly  [NCH];
  logic         want [NCH];
  logic         en   [NCH];
  logic         hold_act;
  logic [W-1:0] hold_cnt;

  assign rx_base = (cur_tx && guard_dly > rx_ana_on_dly) ? guard_dly : rx_ana_on_dly;
  assign rx_eff  = (retune_en && pll_retune_dly > rx_base) ? pll_retune_dly : rx_base;
  assign tx_eff  = (retune_en && pll_retune_dly > tx_ana_on_dly) ? pll_retune_dly : tx_ana_on_dly;

  assign dly[0] = rx_eff;       assign want[0] = !dir_tx;
  assign dly[1] = tx_eff;       assign want[1] = dir_tx;
  assign dly[2] = rx_if_on_dly; assign want[2] = !dir_tx;
  assign dly[3] = tx_if_on_dly; assign want[3] = dir_tx;

  always_ff @(posedge clk) begin
    if (!rst_n)   cur_tx <= 1'b0;
    else if (hop) cur_tx <= dir_tx;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic         on_q, pend;
    logic [W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_q <= 1'b0;
        pend <= 1'b0;
        cnt  <= '0;
      end else if (hop) begin
        on_q <= want[ch] && dly[ch] == '0;
        pend <= want[ch] && dly[ch] != '0;
        cnt  <= dly[ch];
      end else if (pend) begin
        cnt <= cnt - 1'b1;
        if (cnt == W'(1)) begin
          on_q <= 1'b1;
          pend <= 1'b0;
        end
      end
    end
    assign en[ch] = on_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_act <= 1'b0;
      hold_cnt <= '0;
    end else if (hop) begin
      hold_act <= rx_if_en && rx_if_hold_dly != '0;
      hold_cnt <= rx_if_hold_dly;
    end else if (hold_act) begin
      hold_cnt <= hold_cnt - 1'b1;
      if (hold_cnt == W'(1)) hold_act <= 1'b0;
    end
  end

  assign rx_ana_en = en[0];
  assign rx_lna_en = en[0];
  assign tx_ana_en = en[1];
  assign rx_if_en  = en[2] | hold_act;
  assign tx_if_en  = en[3];
endmodule

// File: rtl/hop_power_seq_chk.sv
module hop_power_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hop,
  input logic         dir_tx,
  input logic         retune_en,
  input logic [W-1:0] rx_ana_on_dly,
  input logic [W-1:0] tx_ana_on_dly,
  input logic [W-1:0] guard_dly,
  input logic [W-1:0] pll_retune_dly,
  input logic [W-1:0] rx_if_on_dly,
  input logic [W-1:0] tx_if_on_dly,
  input logic [W-1:0] rx_if_hold_dly,
  input logic         rx_ana_en,
  input logic         rx_lna_en,
  input logic         tx_ana_en,
  input logic         rx_if_en,
  input logic         tx_if_en
);
  logic [15:0] since;
  logic        frame_tx, prev_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since    <= '0;
      frame_tx <= 1'b0;
      prev_tx  <= 1'b0;
    end else if (hop) begin
      since    <= '0;
      frame_tx <= dir_tx;
      prev_tx  <= frame_tx;
    end else if (since != 16'hFFFF) begin
      since <= since + 1'b1;
    end
  end

  assert_rx_hop_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hop && !dir_tx |=> !tx_ana_en && !tx_if_en);
  assert_tx_hop_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hop && dir_tx |=> !rx_ana_en && !rx_lna_en);
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ana_en && tx_ana_en));
  assert_guard_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ana_en) && !hop && prev_tx |-> since >= 16'(guard_dly));
  assert_tx_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ana_en) && !hop |-> since >= 16'(tx_ana_on_dly));
  assert_retune_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ana_en) && !hop && retune_en |-> since >= 16'(pll_retune_dly));
  assert_retune_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ana_en) && !hop && retune_en |-> since >= 16'(pll_retune_dly));
  assert_iface_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_if_en) |-> frame_tx);
endmodule

bind hop_power_seq hop_power_seq_chk #(.W(W)) u_chk (.*);

// File: tb/test_hop_power_seq.sv
module test_hop_power_seq;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, hop = 1'b0, dir_tx = 1'b0, retune_en = 1'b0;
  logic [W-1:0] rx_on = '0, tx_on = '0, guard = '0, pll = '0;
  logic [W-1:0] rxif_on = '0, txif_on = '0, hold = '0;
  logic rx_ana_en, rx_lna_en, tx_ana_en, rx_if_en, tx_if_en;
  int n_chk = 0, n_fail = 0;
  bit prev_tx_b = 0, prev_rxif = 0;

  always #5 clk = ~clk;

  hop_power_seq #(.W(W)) i_hop_power_seq (
    .clk(clk), .rst_n(rst_n), .hop(hop), .dir_tx(dir_tx), .retune_en(retune_en),
    .rx_ana_on_dly(rx_on), .tx_ana_on_dly(tx_on), .guard_dly(guard),
    .pll_retune_dly(pll), .rx_if_on_dly(rxif_on), .tx_if_on_dly(txif_on),
    .rx_if_hold_dly(hold), .rx_ana_en(rx_ana_en), .rx_lna_en(rx_lna_en),
    .tx_ana_en(tx_ana_en), .rx_if_en(rx_if_en), .tx_if_en(tx_if_en));

  task automatic chk(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic frame(input bit d, input int len, input string tg);
    int dr, dt;
    bit e_rxa, e_txa, e_rxif, e_txif;
    dr = int'(rx_on);
    if (prev_tx_b && int'(guard) > dr) dr = int'(guard);
    if (retune_en && int'(pll) > dr) dr = int'(pll);
    dt = int'(tx_on);
    if (retune_en && int'(pll) > dt) dt = int'(pll);
    e_rxif = prev_rxif;
    dir_tx = d;
    hop = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      hop = 1'b0;
      e_rxa  = !d && k >= dr;
      e_txa  = d && k >= dt;
      e_txif = d && k >= int'(txif_on);
      e_rxif = (!d && k >= int'(rxif_on)) || (prev_rxif && k < int'(hold));
      chk(rx_ana_en, e_rxa, {tg, " R1 R3 rx_ana_en"});
      chk(rx_lna_en, e_rxa, {tg, " R5 rx_lna_en"});
      chk(tx_ana_en, e_txa, {tg, " R1 R4 tx_ana_en"});
      chk(rx_if_en, e_rxif, {tg, " R6 R7 rx_if_en"});
      chk(tx_if_en, e_txif, {tg, " R7 tx_if_en"});
      chk(!(rx_ana_en && tx_ana_en), 1'b1, {tg, " R2 exclusive"});
    end
    prev_tx_b = d;
    prev_rxif = e_rxif;
  endtask

  initial begin
    bit seq [7] = '{0, 1, 0, 0, 1, 1, 0};
    repeat (3) @(negedge clk);
    chk(rx_ana_en | rx_lna_en | tx_ana_en | rx_if_en | tx_if_en, 1'b0, "R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    rxif_on = 8'd1;
    txif_on = 8'd2;
    pll = 8'd5;
    for (int gi = 0; gi < 3; gi++)
      for (int ri = 0; ri < 2; ri++)
        for (int rt = 0; rt < 2; rt++) begin
          guard = 8'(gi * 3);
          rx_on = ri ? 8'd2 : 8'd0;
          tx_on = ri ? 8'd0 : 8'd4;
          hold  = ri ? 8'd0 : 8'd3;
          retune_en = rt[0];
          for (int f = 0; f < 7; f++) frame(seq[f], 16, rt ? "R8 sweep" : "sweep");
        end
    retune_en = 1'b0;
    guard = 8'd4; rx_on = 8'd1; tx_on = 8'd6; hold = 8'd2;
    frame(1'b1, 3, "R9 short tx");
    frame(1'b0, 16, "R9 after short");
    frame(1'b0, 2, "R9 short rx");
    frame(1'b1, 16, "R9 tx after short rx");
    frame(1'b0, 16, "R9 tail");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule